// File: doc/BRIEF.md
# NAND Sector Hamming Checker and Corrector

This block watches the bytes of one flash sector as they stream past and builds a single-error-correcting parity code over them. A sector holds 512 bytes. Each data bit has a 12-bit address. The low three address bits select the bit inside the byte, and the upper nine bits are the byte index. For each address bit the block keeps two parities: one over the data bits whose address bit is 0, and one over those whose address bit is 1. The 24 parity bits are inverted and packed into one code word. Because of the inversion, a fully erased sector (all 0xFF) gives the code 0xFFFFFF, which is what an erased spare area reads back as.

When the last byte of a sector is accepted, the block XORs the code it calculated with the code read from the spare area. It then decides whether the sector is clean, holds one flipped data bit, holds an error only in the stored code, or cannot be repaired. For a repairable data error it outputs the byte offset and the bit to invert. The block does not modify the data and does not buffer the page. It accepts one byte per clock and can take sectors back to back.

Top module: `nand_ecc_chk`

## Requirements
- R1: While reset is held and after its release, before any sector completes: `done_o`=0, `status_o`=00, `calc_code_o`=0, `fix_byte_o`=0 and `fix_bit_o`=0.
- R2: Give data bit i of byte b the address a = {b[8:0], i[2:0]}. For each address bit k (0..11), L[k] is the XOR of every data bit whose a[k]=0, and H[k] is the XOR of every data bit whose a[k]=1. The reported code is ~{H, L}: H sits in bits 23:12 and L in bits 11:0. Bits 7:0 are the first spare byte, bits 15:8 the second and bits 23:16 the third, for both `calc_code_o` and `stored_code_i`.
- R3: A sector of 512 bytes all equal to 0xFF gives the code 0xFFFFFF and checks clean against a stored code of 0xFFFFFF.
- R4: `done_o` is high for exactly one cycle, the cycle after the clock edge that accepts the 512th byte. `stored_code_i` is sampled at that same edge. `calc_code_o`, `status_o`, `fix_byte_o` and `fix_bit_o` hold that sector's result from this point until the next `done_o`.
- R5: Define the syndrome S = calculated code XOR stored code. When S = 0, `status_o` = 00 (clean).
- R6: When S[23:12] XOR S[11:0] = 0xFFF, `status_o` = 01 (data bit corrected), `fix_byte_o` = S[23:15] and `fix_bit_o` = S[14:12]. A single flipped data bit at byte b, bit i gives exactly these values.
- R7: When S has exactly one bit set, `status_o` = 10 (error in the stored code only), and `fix_byte_o` and `fix_bit_o` are 0.
- R8: Any other nonzero S, including any two flipped data bits, gives `status_o` = 11 (uncorrectable), with `fix_byte_o` and `fix_bit_o` equal to 0.
- R9: A byte is taken only in a cycle where both `byte_vld_i` and `ecc_en_i` are high. Bytes presented in any other cycle change neither the code nor the byte count.
- R10: `sos_i` clears the parity state and the byte count. It overrides any byte offered in the same cycle and produces no `done_o`.
- R11: After a sector completes, the next sector starts from a cleared state with no idle cycle needed. Its first byte may arrive in the same cycle that `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_en_i | input | 1 | Accumulation enable |
| sos_i | input | 1 | Start of sector: clears the running state |
| byte_vld_i | input | 1 | Data byte valid |
| byte_i | input | 8 | Data byte |
| stored_code_i | input | 24 | Code read from the spare area, sampled with the last byte |
| calc_code_o | output | 24 | Calculated (inverted) code of the last sector |
| done_o | output | 1 | One-cycle strobe marking a new result |
| status_o | output | 2 | 00 clean, 01 corrected, 10 code-only error, 11 uncorrectable |
| fix_byte_o | output | 9 | Byte offset to repair (status 01 only) |
| fix_bit_o | output | 3 | Bit position to repair (status 01 only) |

## Verification
Some properties are checked by assertions on every cycle. These include the one-cycle shape of the done strobe, and the link between the reported status and the syndrome formed from the output code and the stored code of the previous cycle. They also check that the repair location matches the upper syndrome half, and that a start strobe clears the state and suppresses completion. Other behaviours need the bench's sector scenarios. Only those show that the parity is correct, because the bench computes expected codes from the data. The scenarios also sweep single-bit data flips over the boundary bytes and every bit lane, flip every stored-code bit in turn, check an erased page and double faults, and cover gaps, disabled bytes, a mid-stream restart and back-to-back sectors.

// File: rtl/nand_ecc_pkg.sv
// Shared types for the sector ECC checker.
// Assumes the status encoding below is decoded by whoever consumes status_o.
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_CODE  = 2'b10,
        ST_FATAL = 2'b11
    } ecc_status_e;

endpackage

// File: rtl/nand_ecc_lane_par.sv
// Per-byte parity contributions: column parities (split by bit-in-byte
// address bit, low and high halves) and the whole-byte parity.
// Assumes DATA_W is a power of two.
module nand_ecc_lane_par #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]         byte_i,
    output logic [$clog2(DATA_W)-1:0] col_lo_o,
    output logic [$clog2(DATA_W)-1:0] col_hi_o,
    output logic                      row_par_o
);
    localparam int BIT_AW = $clog2(DATA_W);

    // Mask of bit lanes whose address bit k equals want_one.
    function automatic logic [DATA_W-1:0] lane_mask(input int k, input logic want_one);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = ((((i >> k) & 1) == 1) == want_one);
        end
        return m;
    endfunction

    for (genvar k = 0; k < BIT_AW; k++) begin : g_col
        // Column parity pair for bit-address bit k.
        assign col_lo_o[k] = ^(byte_i & lane_mask(k, 1'b0));
        assign col_hi_o[k] = ^(byte_i & lane_mask(k, 1'b1));
    end

    assign row_par_o = ^byte_i;

endmodule

// File: rtl/nand_ecc_accum.sv
// Running parity halves and byte counter for one sector.
// sum_*_o present the halves including the byte offered this cycle, so the
// parent can classify on the edge that takes the last byte.
// Assumes SECTOR_BYTES and DATA_W are powers of two.
module nand_ecc_accum #(
    parameter int DATA_W       = 8,
    parameter int SECTOR_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  take_i,
    input  logic [DATA_W-1:0]     byte_i,
    output logic [$clog2(DATA_W)+$clog2(SECTOR_BYTES)-1:0] sum_lo_o,
    output logic [$clog2(DATA_W)+$clog2(SECTOR_BYTES)-1:0] sum_hi_o,
    output logic                  last_o
);
    localparam int BIT_AW  = $clog2(DATA_W);
    localparam int BYTE_AW = $clog2(SECTOR_BYTES);
    localparam int HALF_W  = BIT_AW + BYTE_AW;
    localparam logic [BYTE_AW-1:0] LAST_IDX = BYTE_AW'(SECTOR_BYTES - 1);

    logic [BYTE_AW-1:0] cnt_q;
    logic [HALF_W-1:0]  lo_q, hi_q;
    logic [HALF_W-1:0]  add_lo, add_hi;
    logic [BIT_AW-1:0]  col_lo, col_hi;
    logic               row_par;

    nand_ecc_lane_par #(.DATA_W(DATA_W)) u_lane (
        .byte_i    (byte_i),
        .col_lo_o  (col_lo),
        .col_hi_o  (col_hi),
        .row_par_o (row_par)
    );

    assign add_lo[BIT_AW-1:0] = col_lo;
    assign add_hi[BIT_AW-1:0] = col_hi;

    for (genvar j = 0; j < BYTE_AW; j++) begin : g_row
        // Steer the byte parity into the half chosen by byte-index bit j.
        assign add_lo[BIT_AW+j] = row_par & ~cnt_q[j];
        assign add_hi[BIT_AW+j] = row_par &  cnt_q[j];
    end

    assign sum_lo_o = lo_q ^ add_lo;
    assign sum_hi_o = hi_q ^ add_hi;
    assign last_o   = take_i && (cnt_q == LAST_IDX);

    // Update the halves and count; restart after the final byte or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (take_i) begin
            if (cnt_q == LAST_IDX) begin
                cnt_q <= '0;
                lo_q  <= '0;
                hi_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                lo_q  <= sum_lo_o;
                hi_q  <= sum_hi_o;
            end
        end
    end

    a_r10_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && lo_q == '0 && hi_q == '0));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !clr_i) |=> ($stable(cnt_q) && $stable(lo_q) && $stable(hi_q)));

    a_r11_wrap_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !clr_i) |=> (cnt_q == '0 && lo_q == '0 && hi_q == '0));

endmodule

// File: rtl/nand_ecc_classify.sv
// Syndrome decode: compares a calculated and a stored code and names the
// outcome plus the data location to repair. Purely combinational.
// Assumes the code is {upper half, lower half}, each HALF_W bits wide.
module nand_ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [2*($clog2(DATA_W)+$clog2(SECTOR_BYTES))-1:0] calc_i,
    input  logic [2*($clog2(DATA_W)+$clog2(SECTOR_BYTES))-1:0] stored_i,
    output ecc_status_e                  status_o,
    output logic [$clog2(SECTOR_BYTES)-1:0] fix_byte_o,
    output logic [$clog2(DATA_W)-1:0]    fix_bit_o
);
    localparam int BIT_AW  = $clog2(DATA_W);
    localparam int BYTE_AW = $clog2(SECTOR_BYTES);
    localparam int HALF_W  = BIT_AW + BYTE_AW;
    localparam int CODE_W  = 2 * HALF_W;

    logic [CODE_W-1:0]  syn;
    logic [HALF_W-1:0]  syn_hi, syn_lo;
    logic [BYTE_AW-1:0] offset;
    logic               mirrored, in_range;

    assign syn      = calc_i ^ stored_i;
    assign syn_hi   = syn[CODE_W-1:HALF_W];
    assign syn_lo   = syn[HALF_W-1:0];
    assign mirrored = ((syn_hi ^ syn_lo) == '1);
    assign offset   = syn_hi[HALF_W-1:BIT_AW];
    assign in_range = (32'(offset) < 32'(SECTOR_BYTES));

    // Priority decode of the syndrome into status and repair location.
    always_comb begin
        status_o   = ST_FATAL;
        fix_byte_o = '0;
        fix_bit_o  = '0;
        if (syn == '0) begin
            status_o = ST_CLEAN;
        end else if (mirrored && in_range) begin
            status_o   = ST_FIXED;
            fix_byte_o = offset;
            fix_bit_o  = syn_hi[BIT_AW-1:0];
        end else if ($onehot(syn)) begin
            status_o = ST_CODE;
        end
    end

endmodule

// File: rtl/nand_ecc_chk.sv
// Sector ECC checker-corrector top. Accepts one byte per clock, and on the
// edge that takes the last byte of a sector registers the inverted code,
// the comparison status against stored_code_i and the repair location.
// Assumes stored_code_i is valid in the cycle the last byte is offered.
module nand_ecc_chk
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SECTOR_BYTES = 512
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ecc_en_i,
    input  logic                              sos_i,
    input  logic                              byte_vld_i,
    input  logic [DATA_W-1:0]                 byte_i,
    input  logic [2*($clog2(DATA_W)+$clog2(SECTOR_BYTES))-1:0] stored_code_i,
    output logic [2*($clog2(DATA_W)+$clog2(SECTOR_BYTES))-1:0] calc_code_o,
    output logic                              done_o,
    output logic [1:0]                        status_o,
    output logic [$clog2(SECTOR_BYTES)-1:0]   fix_byte_o,
    output logic [$clog2(DATA_W)-1:0]         fix_bit_o
);
    localparam int BIT_AW  = $clog2(DATA_W);
    localparam int BYTE_AW = $clog2(SECTOR_BYTES);
    localparam int HALF_W  = BIT_AW + BYTE_AW;
    localparam int CODE_W  = 2 * HALF_W;

    logic               take, last;
    logic [HALF_W-1:0]  sum_lo, sum_hi;
    logic [CODE_W-1:0]  calc_nxt;
    ecc_status_e        status_nxt;
    logic [BYTE_AW-1:0] fix_byte_nxt;
    logic [BIT_AW-1:0]  fix_bit_nxt;

    assign take     = byte_vld_i && ecc_en_i && !sos_i;
    assign calc_nxt = ~{sum_hi, sum_lo};

    nand_ecc_accum #(.DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sos_i),
        .take_i   (take),
        .byte_i   (byte_i),
        .sum_lo_o (sum_lo),
        .sum_hi_o (sum_hi),
        .last_o   (last)
    );

    nand_ecc_classify #(.DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES)) u_classify (
        .calc_i     (calc_nxt),
        .stored_i   (stored_code_i),
        .status_o   (status_nxt),
        .fix_byte_o (fix_byte_nxt),
        .fix_bit_o  (fix_bit_nxt)
    );

    // Capture the sector result on the edge that takes its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            calc_code_o <= '0;
            status_o    <= ST_CLEAN;
            fix_byte_o  <= '0;
            fix_bit_o   <= '0;
        end else begin
            done_o <= last;
            if (last) begin
                calc_code_o <= calc_nxt;
                status_o    <= status_nxt;
                fix_byte_o  <= fix_byte_nxt;
                fix_bit_o   <= fix_bit_nxt;
            end
        end
    end

    // Observation register: stored code one cycle back, for the checks below.
    logic [CODE_W-1:0] stored_prev_q;
    logic [CODE_W-1:0] syn_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) stored_prev_q <= '0;
        else        stored_prev_q <= stored_code_i;
    end
    assign syn_seen = calc_code_o ^ stored_prev_q;

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_clean_iff_equal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((status_o == ST_CLEAN) == (syn_seen == '0)));

    a_r6_fix_location: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == ST_FIXED) |->
            ({fix_byte_o, fix_bit_o} == syn_seen[CODE_W-1:HALF_W]
             && (syn_seen[CODE_W-1:HALF_W] ^ syn_seen[HALF_W-1:0]) == '1));

    a_r7_code_only: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == ST_CODE) |->
            ($countones(syn_seen) == 1 && fix_byte_o == '0 && fix_bit_o == '0));

    a_r8_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == ST_FATAL) |->
            (syn_seen != '0 && fix_byte_o == '0 && fix_bit_o == '0));

    a_r10_no_done_on_sos: assert property (@(posedge clk) disable iff (!rst_n)
        sos_i |=> !done_o);

endmodule

// File: tb/nand_ecc_chk_tb_top.sv
// Self-checking bench: streams whole sectors and compares against codes
// computed arithmetically from the data.
module nand_ecc_chk_tb_top;
    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en_i = 1'b0;
    logic        sos_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [23:0] stored_code_i = '0;
    logic [23:0] calc_code_o;
    logic        done_o;
    logic [1:0]  status_o;
    logic [8:0]  fix_byte_o;
    logic [2:0]  fix_bit_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  sec [NB];
    logic [23:0] got_code;
    logic [1:0]  got_status;
    logic [8:0]  got_byte;
    logic [2:0]  got_bit;
    logic        got_done;
    logic        got_done_after;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    nand_ecc_chk dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ecc_en_i      (ecc_en_i),
        .sos_i         (sos_i),
        .byte_vld_i    (byte_vld_i),
        .byte_i        (byte_i),
        .stored_code_i (stored_code_i),
        .calc_code_o   (calc_code_o),
        .done_o        (done_o),
        .status_o      (status_o),
        .fix_byte_o    (fix_byte_o),
        .fix_bit_o     (fix_bit_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_code();
        logic [11:0] lo = '0;
        logic [11:0] hi = '0;
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 8; i++) begin
                if (sec[b][i]) begin
                    logic [11:0] a;
                    a = {b[8:0], i[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (a[k]) hi[k] = ~hi[k];
                        else      lo[k] = ~lo[k];
                    end
                end
            end
        end
        return ~{hi, lo};
    endfunction

    function automatic logic [7:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic fill_pattern();
        for (int b = 0; b < NB; b++) sec[b] = rnd();
    endtask

    task automatic capture();
        got_done   = done_o;
        got_code   = calc_code_o;
        got_status = status_o;
        got_byte   = fix_byte_o;
        got_bit    = fix_bit_o;
    endtask

    // Drive one sector; optional gap cycles (disabled byte, invalid byte).
    task automatic feed(input logic [23:0] stored, input bit gaps, input bit cap_first);
        for (int b = 0; b < NB; b++) begin
            if (gaps) begin
                @(negedge clk);
                byte_vld_i = 1'b1; ecc_en_i = 1'b0; byte_i = ~sec[b];
                @(negedge clk);
                byte_vld_i = 1'b0; ecc_en_i = 1'b1; byte_i = rnd();
            end
            @(negedge clk);
            if (cap_first && b == 0) capture();
            byte_vld_i = 1'b1; ecc_en_i = 1'b1; byte_i = sec[b];
            stored_code_i = stored;
        end
    endtask

    task automatic finish_sector();
        @(negedge clk);
        capture();
        byte_vld_i = 1'b0;
        @(negedge clk);
        got_done_after = done_o;
    endtask

    task automatic run(input logic [23:0] stored);
        feed(stored, 1'b0, 1'b0);
        finish_sector();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] good;
        int pos_b [7] = '{0, 1, 2, 255, 256, 510, 511};
        int pair  [6][4] = '{'{0,0,0,1}, '{5,3,400,3}, '{511,7,0,0},
                             '{100,2,300,6}, '{17,4,18,4}, '{256,0,255,7}};

        repeat (4) @(negedge clk);
        chk("R1", "done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done", 32'(done_o), 0);
        chk("R1", "status", 32'(status_o), 0);
        chk("R1", "code", 32'(calc_code_o), 0);
        chk("R1", "fix", 32'({fix_byte_o, fix_bit_o}), 0);

        // R3: erased sector
        for (int b = 0; b < NB; b++) sec[b] = 8'hFF;
        run(24'hFFFFFF);
        chk("R3", "erased code", 32'(got_code), 32'hFFFFFF);
        chk("R3", "erased status", 32'(got_status), 0);
        chk("R4", "done", 32'(got_done), 1);
        chk("R4", "done one cycle", 32'(got_done_after), 0);

        // R2/R5: patterned sector clean
        fill_pattern();
        good = exp_code();
        run(good);
        chk("R2", "pattern code", 32'(got_code), 32'(good));
        chk("R5", "pattern status", 32'(got_status), 0);
        chk("R4", "result held", 32'(calc_code_o), 32'(good));

        // R6: single data-bit flips over boundary bytes and every lane
        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < 8; i++) begin
                logic [23:0] flipped;
                sec[pos_b[p]][i] = ~sec[pos_b[p]][i];
                flipped = exp_code();
                run(good);
                chk("R6", "status", 32'(got_status), 1);
                chk("R6", "byte", 32'(got_byte), 32'(pos_b[p]));
                chk("R6", "bit", 32'(got_bit), 32'(i));
                chk("R2", "flipped code", 32'(got_code), 32'(flipped));
                sec[pos_b[p]][i] = ~sec[pos_b[p]][i];
            end
        end

        // R7: each stored-code bit flipped alone
        for (int k = 0; k < 24; k++) begin
            run(good ^ (24'h1 << k));
            chk("R7", "status", 32'(got_status), 2);
            chk("R7", "fix zero", 32'({got_byte, got_bit}), 0);
        end

        // R8: double data faults and a three-bit stored fault
        for (int p = 0; p < 6; p++) begin
            sec[pair[p][0]][pair[p][1]] = ~sec[pair[p][0]][pair[p][1]];
            sec[pair[p][2]][pair[p][3]] = ~sec[pair[p][2]][pair[p][3]];
            run(good);
            chk("R8", "double status", 32'(got_status), 3);
            chk("R8", "fix zero", 32'({got_byte, got_bit}), 0);
            sec[pair[p][0]][pair[p][1]] = ~sec[pair[p][0]][pair[p][1]];
            sec[pair[p][2]][pair[p][3]] = ~sec[pair[p][2]][pair[p][3]];
        end
        run(good ^ 24'h000007);
        chk("R8", "triple stored status", 32'(got_status), 3);

        // R9: disabled and invalid bytes interleaved are ignored
        feed(good, 1'b1, 1'b0);
        finish_sector();
        chk("R9", "gapped code", 32'(got_code), 32'(good));
        chk("R9", "gapped status", 32'(got_status), 0);

        // R10: partial sector then start strobe with a byte offered
        for (int b = 0; b < 100; b++) begin
            @(negedge clk);
            byte_vld_i = 1'b1; ecc_en_i = 1'b1; byte_i = rnd();
        end
        @(negedge clk);
        sos_i = 1'b1; byte_i = 8'h5A;
        @(negedge clk);
        sos_i = 1'b0; byte_vld_i = 1'b0;
        chk("R10", "no done on start", 32'(done_o), 0);
        run(good);
        chk("R10", "restart code", 32'(got_code), 32'(good));
        chk("R10", "restart status", 32'(got_status), 0);

        // R11: back-to-back sectors, second starts while done is high
        feed(good, 1'b0, 1'b0);
        fill_pattern();
        begin
            logic [23:0] second;
            second = exp_code();
            feed(second, 1'b0, 1'b1);
            chk("R11", "first done", 32'(got_done), 1);
            chk("R11", "first code", 32'(got_code), 32'(good));
            finish_sector();
            chk("R11", "second code", 32'(got_code), 32'(second));
            chk("R11", "second status", 32'(got_status), 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule